// File: doc/BRIEF.md
# Multiplexed display RAM bit sequencer

This block picks which of the four bits held in every display RAM word is copied into the segment output register at each step of an LCD multiplex frame. A frame-step tick moves it one bit plane forward through the list that belongs to the active drive mode, and it wraps at the end of that list. The drive modes are static, 1:2, 1:3 and 1:4. Each accepted step gives a one-clock transfer strobe together with the new 2-bit plane index. The downstream RAM read port uses that index.

A sync pulse puts the sequence back on the last plane of the current cycle, so the next step lands on plane 0. A change of drive mode does the same thing. An alternate-bank input moves the displayed planes up by two in the two short modes. Software can then build a new picture in the upper planes and switch to it in one clock. In 1:3 and 1:4 modes that input has no effect.

Top module: `lcd_plane_sequencer`

## Requirements
- R1: A clock edge with `rstN` low clears `xferStb` and loads the sync position of the current mode, so `bitSel` equals that mode's last plane, adjusted for the bank as in R4 and R5.
- R2: With `driveMode` = 3 (1:4), accepted steps give `bitSel` values 0, 1, 2, 3 and then repeat.
- R3: With `driveMode` = 2 (1:3), accepted steps give `bitSel` values 0, 1, 2 and then repeat.
- R4: With `driveMode` = 1 (1:2), accepted steps give `bitSel` values 0, 1 when `bankAlt` = 0 and 2, 3 when `bankAlt` = 1.
- R5: With `driveMode` = 0 (static), `bitSel` is 0 when `bankAlt` = 0 and 2 when `bankAlt` = 1.
- R6: In 1:3 and 1:4 modes, `bankAlt` has no effect on `bitSel`.
- R7: A clock edge with `syncPulse` high sets the position to the last plane of the mode (3, 2, 1, 0 for 1:4, 1:3, 1:2, static). It takes priority over a tick in the same cycle, and no strobe follows.
- R8: A clock edge where `driveMode` differs from its value at the previous edge acts as a sync for the new mode.
- R9: `xferStb` is high for exactly the one cycle after each accepted tick, and `bitSel` already shows the new plane in that cycle. Otherwise the strobe is low and the position holds.
- R10: The effect of the bank input on `bitSel` is registered at each edge and does not move the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| driveMode | input | 2 | 0 static, 1 1:2, 2 1:3, 3 1:4 |
| bankAlt | input | 1 | Show the upper planes in static and 1:2 modes |
| syncPulse | input | 1 | Restart the sequence at the last plane |
| stepTick | input | 1 | Advance one multiplex step |
| bitSel | output | 2 | Bit plane index for the RAM read |
| xferStb | output | 1 | One-clock transfer strobe |

## Verification
The assertions assume that `driveMode`, `bankAlt`, `syncPulse` and `stepTick` are stable around each rising edge. They also assume that the step-order properties apply only after the mode has stayed the same for two edges, which a checker-side arming counter enforces. The stimulus changes every input on the falling edge and samples shortly after the rising edge. It holds each mode for long runs and makes mode changes only at chosen points, so each sequence property gets periods with a stable mode. Sync and tick in the same cycle, together with every ordered pair of modes, cover the priority cases on purpose.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  typedef enum logic [1:0] {
    MODE_STATIC  = 2'd0,
    MODE_DUPLEX  = 2'd1,
    MODE_TRIPLEX = 2'd2,
    MODE_QUAD    = 2'd3
  } driveModeT;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;   // jump to the last plane of the mode
    logic advance;  // move one plane forward and strobe
  } seqCtrlT;
endpackage

// File: rtl/plane_seq_ctrl.sv
module plane_seq_ctrl
  import lcdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] driveMode,
  input  logic      syncPulse,
  input  logic      stepTick,
  output seqCtrlT   ctrl
);
  logic [1:0] prevMode;
  logic       modeChanged;

  // remembers the mode seen at the previous edge, reset included
  always_ff @(posedge clk) begin
    prevMode <= driveMode;
  end

  assign modeChanged = (driveMode != prevMode);

  always_comb begin
    ctrl.reload  = !rstN || syncPulse || modeChanged;
    ctrl.advance = stepTick && !ctrl.reload;
  end
endmodule

// File: rtl/plane_seq_dp.sv
module plane_seq_dp
  import lcdseq_pkg::*;
#(
  parameter int PLANE_W = 2
) (
  input  logic               clk,
  input  logic [1:0]         driveMode,
  input  logic               bankAlt,
  input  seqCtrlT            ctrl,
  output logic [PLANE_W-1:0] bitSel,
  output logic               xferStb
);
  localparam int NUM_PLANES = 1 << PLANE_W;
  localparam logic [PLANE_W-1:0] BANK_OFS = PLANE_W'(NUM_PLANES / 2);

  logic [PLANE_W-1:0] pos;
  logic [PLANE_W-1:0] posNext;
  logic [PLANE_W-1:0] lastPlane;
  logic               bankSwap;

  // the last plane index equals the mode code: 0,1,2,3
  assign lastPlane = PLANE_W'(driveMode);
  // alternate bank only applies in the two short modes
  assign bankSwap  = bankAlt && !driveMode[1];

  always_comb begin
    if (ctrl.reload)
      posNext = lastPlane;
    else if (ctrl.advance)
      posNext = (pos >= lastPlane) ? '0 : pos + PLANE_W'(1);
    else
      posNext = pos;
  end

  always_ff @(posedge clk) begin
    pos     <= posNext;
    bitSel  <= bankSwap ? (posNext | BANK_OFS) : posNext;
    xferStb <= ctrl.advance;
  end
endmodule

// File: rtl/lcd_plane_sequencer.sv
module lcd_plane_sequencer
  import lcdseq_pkg::*;
#(
  parameter int PLANE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         driveMode,
  input  logic               bankAlt,
  input  logic               syncPulse,
  input  logic               stepTick,
  output logic [PLANE_W-1:0] bitSel,
  output logic               xferStb
);
  seqCtrlT seqCtrl;

  plane_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .driveMode (driveMode),
    .syncPulse (syncPulse),
    .stepTick  (stepTick),
    .ctrl      (seqCtrl)
  );

  plane_seq_dp #(.PLANE_W(PLANE_W)) u_dp (
    .clk       (clk),
    .driveMode (driveMode),
    .bankAlt   (bankAlt),
    .ctrl      (seqCtrl),
    .bitSel    (bitSel),
    .xferStb   (xferStb)
  );
endmodule

// File: rtl/plane_seq_chk.sv
module plane_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] driveMode,
  input logic       bankAlt,
  input logic       syncPulse,
  input logic       stepTick,
  input logic [1:0] bitSel,
  input logic       xferStb
);
  logic [1:0] armCnt;
  logic [1:0] modeQ;
  logic       armed;

  always_ff @(posedge clk) begin
    modeQ <= driveMode;
    if (!rstN) armCnt <= 2'd0;
    else if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
  end
  assign armed = (armCnt == 2'd3);

  // R9
  strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferStb |-> $past(stepTick) && !$past(syncPulse));

  // R7
  sync_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPulse |=> !xferStb);

  // R5
  static_plane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(driveMode) == 2'd0) |-> bitSel == {$past(bankAlt), 1'b0});

  // R4
  duplex_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(driveMode) == 2'd1) |-> bitSel[1] == $past(bankAlt));

  // R3
  triplex_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(driveMode) == 2'd2) |-> bitSel != 2'd3);

  // R2
  quad_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(driveMode) == 2'd3 && $past(modeQ) == 2'd3 &&
     $past(stepTick) && !$past(syncPulse)) |-> bitSel == $past(bitSel) + 2'd1);
endmodule

bind lcd_plane_sequencer plane_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .driveMode (driveMode),
  .bankAlt   (bankAlt),
  .syncPulse (syncPulse),
  .stepTick  (stepTick),
  .bitSel    (bitSel),
  .xferStb   (xferStb)
);

// File: tb/sim_lcd_plane_sequencer.sv
`timescale 1ns/1ps
module sim_lcd_plane_sequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] driveMode = 2'd3;
  logic       bankAlt = 1'b0;
  logic       syncPulse = 1'b0;
  logic       stepTick = 1'b0;
  logic [1:0] bitSel;
  logic       xferStb;

  int checks = 0;
  int errors = 0;
  int curMode = 3;
  int nSteps = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  lcd_plane_sequencer u0 (
    .clk(clk), .rstN(rstN), .driveMode(driveMode), .bankAlt(bankAlt),
    .syncPulse(syncPulse), .stepTick(stepTick), .bitSel(bitSel), .xferStb(xferStb)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string modeTag(input int m);
    case (m)
      0: return "R5";
      1: return "R4";
      2: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic runCycle(input bit tk, input bit sy, input int m, input bit b);
    bit reload;
    bit expX;
    int idx;
    int expSel;
    string tag;
    @(negedge clk);
    stepTick = tk; syncPulse = sy; driveMode = 2'(m); bankAlt = b;
    reload = sy || (m != curMode);
    if (sy) tag = "R7";
    else if (m != curMode) tag = "R8";
    else if (b && m >= 2) tag = "R6";
    else tag = modeTag(m);
    if (reload) begin nSteps = 0; expX = 0; end
    else if (tk) begin nSteps++; expX = 1; end
    else expX = 0;
    curMode = m;
    @(posedge clk); #1;
    idx = (m + nSteps) % (m + 1);
    expSel = idx + ((b && m < 2) ? 2 : 0);
    check(tag, bitSel, expSel);
    check("R9", xferStb, expX);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset with a tick present, 1:4 mode
    stepTick = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", bitSel, 3);
    check("R1", xferStb, 0);
    // R1: reset in static mode with alternate bank
    @(negedge clk); driveMode = 2'd0; bankAlt = 1'b1;
    @(posedge clk); #1;
    check("R1", bitSel, 2);
    check("R1", xferStb, 0);
    @(negedge clk); rstN = 1'b1; curMode = 0; nSteps = 0;
    stepTick = 1'b0;

    // sweep every mode and bank, with irregular tick spacing
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        runCycle(0, 1, m, b[0]);
        for (int i = 0; i < 14; i++) runCycle((i % 3) != 2, 0, m, b[0]);
      end
    end

    // R7: sync and tick together in the middle of the sequence
    for (int m = 0; m < 4; m++) begin
      runCycle(0, 1, m, 0);
      runCycle(1, 0, m, 0);
      runCycle(1, 1, m, 0);
      runCycle(1, 0, m, 0);
      runCycle(0, 0, m, 0);
    end

    // R10: bank toggles while stepping in 1:2 and static modes
    for (int m = 0; m < 2; m++) begin
      runCycle(0, 1, m, 0);
      for (int i = 0; i < 8; i++) runCycle(i[0], 0, m, i[1]);
    end

    // R8: every ordered mode pair, change arriving together with a tick
    for (int a = 0; a < 4; a++) begin
      for (int c = 0; c < 4; c++) begin
        if (a != c) begin
          runCycle(0, 1, a, 0);
          runCycle(1, 0, a, 0);
          runCycle(1, 0, c, 1);
          runCycle(1, 0, c, 1);
          runCycle(1, 0, c, 0);
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule